// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns the address bus of a small microcontroller into one-hot selects for an on-chip memory system. The system has four code-memory banks, one scratch SRAM, an internal I/O window and a peripheral I/O window. Each window has a base address and a byte size, which are set up on static configuration inputs before the bus starts running. When an access matches a window, the block also gives the position of the access inside that window, so that the selected memory can use it directly.

The code banks may lie underneath the SRAM and I/O windows. Where an address falls inside both, the SRAM or I/O window wins, and that part of the code bank cannot be reached. The peripheral window takes part only while the port that provides it is in peripheral mode. A density setting gives the size of each code bank. A bus-width mode turns memory offsets into word indices for a 16-bit data bus.

The selects are computed from the address and a global enable, then captured on the address strobe, and they hold steady until the next strobe. A separate error vector is re-evaluated on every clock. It reports configurations that break the placement rules.

Top module: `cs_priority_decoder`

## Requirements
- R1: With `cs_en` high, a strobed address `a` hits code window i when `code_size[i]` is non-zero and `code_base[i] <= a < code_base[i] + code_size[i]`. If several code windows hit, the lowest index wins and only `code_sel[i]` is asserted.
- R2: A hit in the SRAM, internal I/O or peripheral I/O window beats any code hit. Among those three windows the order is SRAM, then internal I/O, then peripheral I/O. A size of zero disables a window.
- R3: The peripheral I/O window can match only while `pio_mode` is 1. With `pio_mode` at 0, an address in that window decodes as if the window were absent.
- R4: At most one select is high at any time. When `cs_en` is high and no window matches, `unmapped` is 1 and no select is asserted.
- R5: Selects, `unmapped` and `offset` update only on a clock edge where `addr_strb` is 1, and they then hold their values. A strobe taken with `cs_en` at 0 clears every select and `unmapped`.
- R6: `offset` is (address − window base) modulo the block size. The block size is 8192 << d bytes for a code bank, where d = min(`dens`, 2). It is 2048 bytes for the SRAM and 256 bytes for either I/O window. When nothing is selected, `offset` is 0.
- R7: With `wide16` at 1, the offset of a code or SRAM access is shifted right by one, which gives a 16-bit word index. I/O offsets stay in bytes.
- R8: `cfg_err[0]` is 1 when any two enabled code windows overlap.
- R9: `cfg_err[1]` is 1 when any two enabled windows among SRAM, internal I/O and peripheral I/O overlap. The peripheral window counts only while `pio_mode` is 1.
- R10: `cfg_err[2]` is 1 when any code window size is larger than the code bank size that the density setting gives.
- R11: `dens` value 3 is reserved. It sets `cfg_err[3]`, and the banks are treated as 32 KB.
- R12: During reset every output is 0. `cfg_err` follows the configuration one clock later, on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_en | input | 1 | Global decode enable |
| addr_strb | input | 1 | Address strobe; captures the decode |
| addr | input | ADDR_W | Bus byte address |
| wide16 | input | 1 | 16-bit data bus mode |
| dens | input | 2 | Code bank density: 0 = 8 KB, 1 = 16 KB, 2 = 32 KB, 3 = reserved |
| pio_mode | input | 1 | Port is in peripheral I/O mode |
| code_base | input | NCODE×ADDR_W | Code window bases |
| code_size | input | NCODE×ADDR_W | Code window sizes in bytes (0 = off) |
| sram_base | input | ADDR_W | SRAM window base |
| sram_size | input | ADDR_W | SRAM window size |
| iio_base | input | ADDR_W | Internal I/O window base |
| iio_size | input | ADDR_W | Internal I/O window size |
| pio_base | input | ADDR_W | Peripheral I/O window base |
| pio_size | input | ADDR_W | Peripheral I/O window size |
| code_sel | output | NCODE | Code bank selects |
| sram_sel | output | 1 | SRAM select |
| iio_sel | output | 1 | Internal I/O select |
| pio_sel | output | 1 | Peripheral I/O select |
| unmapped | output | 1 | Enabled access matched no window |
| offset | output | ADDR_W | Offset inside the selected window |
| cfg_err | output | 4 | Configuration rule violations (R8–R11) |

## Verification
The hard case is an address that lies inside several windows at once, combined with a configuration that is only legal in some of its settings. An example is a peripheral window that overlaps the SRAM: this is legal only while `pio_mode` is 0. Directed stimulus places the SRAM and both I/O windows inside code bank 0. It then strobes addresses on each edge of those windows, toggles `pio_mode` and `wide16`, and changes `dens` so that the same sizes become oversized. After that, long runs with random overlapping configurations and random addresses are checked cycle by cycle against a behavioural priority model.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    typedef enum logic [1:0] {
        DENS_8K   = 2'd0,
        DENS_16K  = 2'd1,
        DENS_32K  = 2'd2,
        DENS_RSVD = 2'd3
    } dens_e;

    localparam int ERR_CODE_OVL = 0;
    localparam int ERR_IO_OVL   = 1;
    localparam int ERR_CODE_BIG = 2;
    localparam int ERR_DENS     = 3;
    localparam int ERR_W        = 4;

    // window slots after the code banks
    localparam int SLOT_SRAM = 0;
    localparam int SLOT_IIO  = 1;
    localparam int SLOT_PIO  = 2;
    localparam int NIOWIN    = 3;

    // shift applied to the bank unit size for a density code
    function automatic int unsigned dens_shift(input logic [1:0] d);
        return (d == DENS_RSVD) ? 2 : int'(d);
    endfunction

endpackage

// File: rtl/cs_win_match.sv
module cs_win_match #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic [ADDR_W-1:0] blk_mask,
    output logic              hit,
    output logic [ADDR_W-1:0] off
);
    logic [ADDR_W:0]   win_end;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        win_end = {1'b0, base} + {1'b0, size};
        diff    = addr - base;
        hit     = (size != '0) && (addr >= base) && ({1'b0, addr} < win_end);
        off     = diff & blk_mask;
    end
endmodule

// File: rtl/cs_rule_check.sv
module cs_rule_check
    import cs_dec_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NCODE  = 4
) (
    input  logic [NCODE-1:0][ADDR_W-1:0] code_base,
    input  logic [NCODE-1:0][ADDR_W-1:0] code_size,
    input  logic [NIOWIN-1:0][ADDR_W-1:0] io_base,
    input  logic [NIOWIN-1:0][ADDR_W-1:0] io_size,
    input  logic                          pio_mode,
    input  logic [1:0]                    dens,
    input  logic [ADDR_W:0]               code_blk,
    output logic [ERR_W-1:0]              err
);
    function automatic logic ranges_meet(
        input logic [ADDR_W-1:0] ab, input logic [ADDR_W-1:0] as,
        input logic [ADDR_W-1:0] bb, input logic [ADDR_W-1:0] bs);
        logic [ADDR_W:0] ae;
        logic [ADDR_W:0] be;
        ae = {1'b0, ab} + {1'b0, as};
        be = {1'b0, bb} + {1'b0, bs};
        return (as != '0) && (bs != '0) &&
               ({1'b0, ab} < be) && ({1'b0, bb} < ae);
    endfunction

    logic              code_ovl;
    logic              io_ovl;
    logic              code_big;
    logic [NIOWIN-1:0] io_live;

    always_comb begin
        io_live           = '1;
        io_live[SLOT_PIO] = pio_mode;
    end

    always_comb begin
        code_ovl = 1'b0;
        for (int i = 0; i < NCODE; i++) begin
            for (int j = i + 1; j < NCODE; j++) begin
                if (ranges_meet(code_base[i], code_size[i], code_base[j], code_size[j]))
                    code_ovl = 1'b1;
            end
        end
    end

    always_comb begin
        io_ovl = 1'b0;
        for (int i = 0; i < NIOWIN; i++) begin
            for (int j = i + 1; j < NIOWIN; j++) begin
                if (io_live[i] && io_live[j] &&
                    ranges_meet(io_base[i], io_size[i], io_base[j], io_size[j]))
                    io_ovl = 1'b1;
            end
        end
    end

    always_comb begin
        code_big = 1'b0;
        for (int i = 0; i < NCODE; i++) begin
            if ({1'b0, code_size[i]} > code_blk)
                code_big = 1'b1;
        end
    end

    always_comb begin
        err               = '0;
        err[ERR_CODE_OVL] = code_ovl;
        err[ERR_IO_OVL]   = io_ovl;
        err[ERR_CODE_BIG] = code_big;
        err[ERR_DENS]     = (dens == DENS_RSVD);
    end
endmodule

// File: rtl/cs_priority_decoder.sv
module cs_priority_decoder
    import cs_dec_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int NCODE      = 4,
    parameter int CODE_UNIT  = 8192,
    parameter int SRAM_BYTES = 2048,
    parameter int IO_BYTES   = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_en,
    input  logic                         addr_strb,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wide16,
    input  logic [1:0]                   dens,
    input  logic                         pio_mode,
    input  logic [NCODE-1:0][ADDR_W-1:0] code_base,
    input  logic [NCODE-1:0][ADDR_W-1:0] code_size,
    input  logic [ADDR_W-1:0]            sram_base,
    input  logic [ADDR_W-1:0]            sram_size,
    input  logic [ADDR_W-1:0]            iio_base,
    input  logic [ADDR_W-1:0]            iio_size,
    input  logic [ADDR_W-1:0]            pio_base,
    input  logic [ADDR_W-1:0]            pio_size,
    output logic [NCODE-1:0]             code_sel,
    output logic                         sram_sel,
    output logic                         iio_sel,
    output logic                         pio_sel,
    output logic                         unmapped,
    output logic [ADDR_W-1:0]            offset,
    output logic [ERR_W-1:0]             cfg_err
);
    localparam int NWIN    = NCODE + NIOWIN;
    localparam int PICK_W  = (NCODE > 1) ? $clog2(NCODE) : 1;

    typedef struct packed {
        logic [NCODE-1:0]  code;
        logic              sram;
        logic              iio;
        logic              pio;
        logic              unmapped;
        logic [ADDR_W-1:0] off;
        logic [ERR_W-1:0]  err;
    } dec_state_t;

    dec_state_t st_d, st_q;

    // window table
    logic [NWIN-1:0][ADDR_W-1:0]  win_base;
    logic [NWIN-1:0][ADDR_W-1:0]  win_size;
    logic [NWIN-1:0][ADDR_W-1:0]  win_mask;
    logic [NWIN-1:0]              win_hit;
    logic [NWIN-1:0][ADDR_W-1:0]  win_off;
    logic [NIOWIN-1:0][ADDR_W-1:0] io_base;
    logic [NIOWIN-1:0][ADDR_W-1:0] io_size;

    logic [ADDR_W:0]   code_blk;
    logic [ADDR_W-1:0] code_mask;
    logic [ERR_W-1:0]  err_w;

    always_comb begin
        code_blk  = (ADDR_W+1)'(CODE_UNIT) << dens_shift(dens);
        code_mask = code_blk[ADDR_W-1:0] - 1'b1;
    end

    always_comb begin
        io_base[SLOT_SRAM] = sram_base;
        io_size[SLOT_SRAM] = sram_size;
        io_base[SLOT_IIO]  = iio_base;
        io_size[SLOT_IIO]  = iio_size;
        io_base[SLOT_PIO]  = pio_base;
        io_size[SLOT_PIO]  = pio_size;
    end

    genvar g;
    generate
        for (g = 0; g < NWIN; g++) begin : g_win
            if (g < NCODE) begin : g_code
                always_comb begin
                    win_base[g] = code_base[g];
                    win_size[g] = code_size[g];
                    win_mask[g] = code_mask;
                end
            end else if (g == NCODE + SLOT_SRAM) begin : g_sram
                always_comb begin
                    win_base[g] = io_base[g-NCODE];
                    win_size[g] = io_size[g-NCODE];
                    win_mask[g] = ADDR_W'(SRAM_BYTES - 1);
                end
            end else begin : g_io
                always_comb begin
                    win_base[g] = io_base[g-NCODE];
                    win_size[g] = io_size[g-NCODE];
                    win_mask[g] = ADDR_W'(IO_BYTES - 1);
                end
            end

            cs_win_match #(.ADDR_W(ADDR_W)) u_match (
                .addr     (addr),
                .base     (win_base[g]),
                .size     (win_size[g]),
                .blk_mask (win_mask[g]),
                .hit      (win_hit[g]),
                .off      (win_off[g])
            );
        end
    endgenerate

    cs_rule_check #(.ADDR_W(ADDR_W), .NCODE(NCODE)) u_rules (
        .code_base (code_base),
        .code_size (code_size),
        .io_base   (io_base),
        .io_size   (io_size),
        .pio_mode  (pio_mode),
        .dens      (dens),
        .code_blk  (code_blk),
        .err       (err_w)
    );

    // lowest-index code bank among the hits
    logic              code_any;
    logic [PICK_W-1:0] code_pick;

    always_comb begin
        code_any  = 1'b0;
        code_pick = '0;
        for (int i = NCODE - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                code_any  = 1'b1;
                code_pick = PICK_W'(i);
            end
        end
    end

    logic hit_sram, hit_iio, hit_pio;
    always_comb begin
        hit_sram = win_hit[NCODE + SLOT_SRAM];
        hit_iio  = win_hit[NCODE + SLOT_IIO];
        hit_pio  = win_hit[NCODE + SLOT_PIO] && pio_mode;
    end

    function automatic logic [ADDR_W-1:0] word_idx(input logic [ADDR_W-1:0] o,
                                                   input logic w);
        return w ? (o >> 1) : o;
    endfunction

    // next-state process
    always_comb begin
        st_d     = st_q;
        st_d.err = err_w;
        if (addr_strb) begin
            st_d.code     = '0;
            st_d.sram     = 1'b0;
            st_d.iio      = 1'b0;
            st_d.pio      = 1'b0;
            st_d.unmapped = 1'b0;
            st_d.off      = '0;
            if (cs_en) begin
                if (hit_sram) begin
                    st_d.sram = 1'b1;
                    st_d.off  = word_idx(win_off[NCODE + SLOT_SRAM], wide16);
                end else if (hit_iio) begin
                    st_d.iio = 1'b1;
                    st_d.off = win_off[NCODE + SLOT_IIO];
                end else if (hit_pio) begin
                    st_d.pio = 1'b1;
                    st_d.off = win_off[NCODE + SLOT_PIO];
                end else if (code_any) begin
                    st_d.code[code_pick] = 1'b1;
                    st_d.off = word_idx(win_off[code_pick], wide16);
                end else begin
                    st_d.unmapped = 1'b1;
                end
            end
        end
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        code_sel = st_q.code;
        sram_sel = st_q.sram;
        iio_sel  = st_q.iio;
        pio_sel  = st_q.pio;
        unmapped = st_q.unmapped;
        offset   = st_q.off;
        cfg_err  = st_q.err;
    end
endmodule

// File: rtl/cs_priority_decoder_chk.sv
module cs_priority_decoder_chk #(
    parameter int ADDR_W     = 20,
    parameter int NCODE      = 4,
    parameter int CODE_UNIT  = 8192,
    parameter int SRAM_BYTES = 2048
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_en,
    input logic                         addr_strb,
    input logic                         pio_mode,
    input logic [1:0]                   dens,
    input logic [NCODE-1:0][ADDR_W-1:0] code_size,
    input logic [NCODE-1:0]             code_sel,
    input logic                         sram_sel,
    input logic                         iio_sel,
    input logic                         pio_sel,
    input logic                         unmapped,
    input logic [ADDR_W-1:0]            offset,
    input logic [3:0]                   cfg_err
);
    logic any_huge;
    always_comb begin
        any_huge = 1'b0;
        for (int i = 0; i < NCODE; i++)
            if (int'(code_size[i]) > 4 * CODE_UNIT) any_huge = 1'b1;
    end

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_sel, sram_sel, iio_sel, pio_sel}));

    p_unmapped_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> ({code_sel, sram_sel, iio_sel, pio_sel} == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strb |=> ($stable(code_sel) && $stable(sram_sel) && $stable(iio_sel)
                        && $stable(pio_sel) && $stable(unmapped) && $stable(offset)));

    p_off_when_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strb && !cs_en) |=> ({code_sel, sram_sel, iio_sel, pio_sel, unmapped} == '0));

    p_pio_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strb && !pio_mode) |=> !pio_sel);

    p_sram_off_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel |-> (int'(offset) < SRAM_BYTES));

    p_huge_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_huge |=> cfg_err[2]);

    p_rsvd_dens_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dens == 2'd3) |=> cfg_err[3]);
endmodule

bind cs_priority_decoder cs_priority_decoder_chk #(
    .ADDR_W(ADDR_W), .NCODE(NCODE), .CODE_UNIT(CODE_UNIT), .SRAM_BYTES(SRAM_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .addr_strb(addr_strb),
    .pio_mode(pio_mode), .dens(dens), .code_size(code_size),
    .code_sel(code_sel), .sram_sel(sram_sel), .iio_sel(iio_sel), .pio_sel(pio_sel),
    .unmapped(unmapped), .offset(offset), .cfg_err(cfg_err)
);

// File: tb/cs_priority_decoder_bench.sv
module cs_priority_decoder_bench;
    localparam int AW = 20;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                cs_en = 0, addr_strb = 0, wide16 = 0, pio_mode = 0;
    logic [AW-1:0]       addr = '0;
    logic [1:0]          dens = 2'd2;
    logic [NC-1:0][AW-1:0] code_base = '0, code_size = '0;
    logic [AW-1:0]       sram_base = '0, sram_size = '0, iio_base = '0, iio_size = '0;
    logic [AW-1:0]       pio_base = '0, pio_size = '0;
    logic [NC-1:0]       code_sel;
    logic                sram_sel, iio_sel, pio_sel, unmapped;
    logic [AW-1:0]       offset;
    logic [3:0]          cfg_err;

    cs_priority_decoder #(.ADDR_W(AW), .NCODE(NC)) u_cs_priority_decoder (
        .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .addr_strb(addr_strb), .addr(addr),
        .wide16(wide16), .dens(dens), .pio_mode(pio_mode),
        .code_base(code_base), .code_size(code_size),
        .sram_base(sram_base), .sram_size(sram_size),
        .iio_base(iio_base), .iio_size(iio_size),
        .pio_base(pio_base), .pio_size(pio_size),
        .code_sel(code_sel), .sram_sel(sram_sel), .iio_sel(iio_sel), .pio_sel(pio_sel),
        .unmapped(unmapped), .offset(offset), .cfg_err(cfg_err)
    );

    int errors = 0;
    int checks = 0;
    string cur_tag = "R12";
    bit done = 0;

    // model state: selected index (-1 none, 0..3 code, 4 sram, 5 iio, 6 pio)
    int  m_sel = -1, m_off = 0;
    bit  m_unm = 0;
    bit  m_err[4] = '{0, 0, 0, 0};

    function automatic bit in_win(longint a, longint b, longint s);
        return (s != 0) && (a >= b) && (a < b + s);
    endfunction

    function automatic bit meet(longint ab, longint as, longint bb, longint bs);
        return (as != 0) && (bs != 0) && (ab < bb + bs) && (bb < ab + as);
    endfunction

    function automatic longint bank_bytes();
        return 64'd8192 << ((dens == 2'd3) ? 2 : int'(dens));
    endfunction

    function automatic longint wbase(int k);
        case (k)
            4: return longint'(sram_base);
            5: return longint'(iio_base);
            6: return longint'(pio_base);
            default: return longint'(code_base[k]);
        endcase
    endfunction

    function automatic longint wsize(int k);
        case (k)
            4: return longint'(sram_size);
            5: return longint'(iio_size);
            6: return pio_mode ? longint'(pio_size) : 0;
            default: return longint'(code_size[k]);
        endcase
    endfunction

    // model of one clock edge with the inputs currently applied
    task automatic model_edge();
        longint a;
        int     pick;
        longint blk;
        int     order[7] = '{4, 5, 6, 0, 1, 2, 3};
        m_err[0] = 0;
        for (int i = 0; i < NC; i++)
            for (int j = i + 1; j < NC; j++)
                if (meet(code_base[i], code_size[i], code_base[j], code_size[j])) m_err[0] = 1;
        m_err[1] = 0;
        for (int i = 4; i < 7; i++)
            for (int j = i + 1; j < 7; j++)
                if (meet(wbase(i), wsize(i), wbase(j), wsize(j))) m_err[1] = 1;
        m_err[2] = 0;
        for (int i = 0; i < NC; i++)
            if (longint'(code_size[i]) > bank_bytes()) m_err[2] = 1;
        m_err[3] = (dens == 2'd3);
        if (addr_strb) begin
            m_sel = -1; m_off = 0; m_unm = 0;
            if (cs_en) begin
                a = longint'(addr);
                pick = -1;
                foreach (order[n])
                    if (pick < 0 && in_win(a, wbase(order[n]), wsize(order[n]))) pick = order[n];
                if (pick < 0) m_unm = 1;
                else begin
                    blk = (pick < 4) ? bank_bytes() : (pick == 4 ? 2048 : 256);
                    m_sel = pick;
                    m_off = int'((a - wbase(pick)) % blk);
                    if (wide16 && pick <= 4) m_off = m_off / 2;
                end
            end
        end
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        int act_sel, nsel;
        logic [6:0] v;
        v = {pio_sel, iio_sel, sram_sel, code_sel};
        nsel = $countones(v);
        act_sel = -1;
        for (int k = 0; k < 7; k++) if (v[k]) act_sel = k;
        if (nsel > 1) act_sel = 99;
        chk(act_sel == m_sel, cur_tag, "select", act_sel, m_sel);
        chk(unmapped == m_unm, (cur_tag == "R5") ? "R5" : "R4", "unmapped", int'(unmapped), int'(m_unm));
        chk(int'(offset) == m_off, wide16 ? "R7" : "R6", "offset", int'(offset), m_off);
        chk(cfg_err[0] == m_err[0], "R8", "err_code_ovl", int'(cfg_err[0]), int'(m_err[0]));
        chk(cfg_err[1] == m_err[1], "R9", "err_io_ovl", int'(cfg_err[1]), int'(m_err[1]));
        chk(cfg_err[2] == m_err[2], "R10", "err_code_big", int'(cfg_err[2]), int'(m_err[2]));
        chk(cfg_err[3] == m_err[3], "R11", "err_dens", int'(cfg_err[3]), int'(m_err[3]));
    endtask

    // inputs are applied at a negedge; this advances one clock and checks
    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic access(logic [AW-1:0] a, string tag);
        cur_tag = tag;
        addr = a; addr_strb = 1;
        tick();
        addr_strb = 0;
    endtask

    task automatic clean_cfg();
        for (int i = 0; i < NC; i++) begin
            code_base[i] = AW'(i * 32'h8000);
            code_size[i] = AW'(32'h8000);
        end
        dens = 2'd2;
        sram_base = AW'(32'h02000); sram_size = AW'(2048);
        iio_base  = AW'(32'h04000); iio_size  = AW'(256);
        pio_base  = AW'(32'h05000); pio_size  = AW'(256);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        cur_tag = "R12";
        compare();
        rst_n = 1;
        clean_cfg();
        cs_en = 1;
        tick();   // R12: cfg_err follows config one clock later

        // R1 code bank decode and offsets
        access(AW'(32'h00100), "R1");
        access(AW'(32'h0A000), "R1");
        access(AW'(32'h1FFFF), "R1");
        access(AW'(32'h18000), "R1");
        // R2 SRAM and I/O win over bank 0, window edges
        access(AW'(32'h02000), "R2");
        access(AW'(32'h027FF), "R2");
        access(AW'(32'h02800), "R2");
        access(AW'(32'h04005), "R2");
        access(AW'(32'h040FF), "R2");
        access(AW'(32'h04100), "R2");
        // R3 peripheral window gated by mode
        access(AW'(32'h05001), "R3");
        pio_mode = 1;
        access(AW'(32'h05001), "R3");
        access(AW'(32'h050FF), "R3");
        // R4 unmapped
        access(AW'(32'h30000), "R4");
        access(AW'(32'hFFFFF), "R4");
        // R7 word mode
        wide16 = 1;
        access(AW'(32'h0A006), "R7");
        access(AW'(32'h027FE), "R7");
        access(AW'(32'h04007), "R7");
        wide16 = 0;
        // R5 hold without strobe, then disabled strobe
        access(AW'(32'h0A000), "R5");
        cur_tag = "R5";
        addr = AW'(32'h02010);
        repeat (3) tick();
        cs_en = 0;
        access(AW'(32'h02010), "R5");
        access(AW'(32'h30000), "R5");
        cs_en = 1;
        // R10 smaller density makes 32K windows oversized; R6 offset wraps
        dens = 2'd0;
        access(AW'(32'h0A123), "R10");
        dens = 2'd1;
        access(AW'(32'h0E123), "R6");
        // R11 reserved density
        dens = 2'd3;
        access(AW'(32'h1C001), "R11");
        dens = 2'd2;
        // R8 code overlap
        code_base[1] = AW'(32'h04000);
        access(AW'(32'h06000), "R8");
        clean_cfg();
        // R9 pio overlapping SRAM only counts when mode on
        pio_base = AW'(32'h02400);
        pio_mode = 0;
        access(AW'(32'h02400), "R9");
        pio_mode = 1;
        access(AW'(32'h02400), "R9");
        iio_base = AW'(32'h027F0); iio_size = AW'(256);
        pio_base = AW'(32'h05000);
        access(AW'(32'h027F8), "R9");
        clean_cfg();

        // random addresses on the clean map
        for (int n = 0; n < 1500; n++) begin
            pio_mode = 1'($urandom);
            wide16   = 1'($urandom);
            cs_en    = ($urandom % 8) != 0;
            addr_strb = ($urandom % 4) != 0;
            addr = AW'($urandom % 32'h24000);
            cur_tag = "R2";
            tick();
        end
        // random configurations
        for (int n = 0; n < 3000; n++) begin
            if (n % 16 == 0) begin
                for (int i = 0; i < NC; i++) begin
                    code_base[i] = AW'($urandom % 32'h40000);
                    code_size[i] = AW'((($urandom % 5) == 0) ? 0 : (256 << ($urandom % 9)));
                end
                sram_base = AW'($urandom % 32'h40000); sram_size = AW'(($urandom % 2) ? 2048 : 0);
                iio_base  = AW'($urandom % 32'h40000); iio_size  = AW'(256 << ($urandom % 3));
                pio_base  = AW'($urandom % 32'h40000); pio_size  = AW'(256);
                dens = 2'($urandom);
            end
            pio_mode = 1'($urandom);
            wide16   = 1'($urandom);
            cs_en    = ($urandom % 8) != 0;
            addr_strb = ($urandom % 4) != 0;
            case ($urandom % 3)
                0: addr = code_base[$urandom % NC] + AW'($urandom % 32'h9000);
                1: addr = sram_base + AW'($urandom % 3000);
                default: addr = AW'($urandom % 32'h48000);
            endcase
            cur_tag = "R1";
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule